// File: doc/BRIEF.md
# Input-Capture Channel with Two-Deep Timestamp Queue

This block timestamps signal edges against a free-running counter. A qualified edge, delivered already filtered as single-cycle rise and fall strobes, copies the current count into a capture register. In queue mode the capture register is backed by a holding register, so the two most recent edge times are kept side by side. The difference between them, which is the period, is also offered directly as an output.

Software programs the edge polarity, the counter prescaler and the queue policy. It reads the capture and holding values through read strobes, and each strobe marks its register empty. A channel flag reports accepted captures. The flag can be cleared explicitly, or cleared by a capture read when fast clear is on. With the no-overwrite option set, registers that still hold unread data are protected from new edges.

Top module: `icq_channel`

## Requirements
- R1: `count_o` resets to 0 and, while `cnt_en` is high, advances by one every 2^`presc_sel` enabled cycles (presc_sel=4 divides by 16). The prescaler phase counter also resets to 0 and only moves while `cnt_en` is high. `count_o` holds while `cnt_en` is low.
- R2: `edge_sel` 2'b00 ignores all edges, 2'b01 reacts to `rise_i`, 2'b10 reacts to `fall_i`, and 2'b11 reacts to either.
- R3: An accepted edge in cycle t loads the value `count_o` has in cycle t into `cap_o` and sets `cap_full_o`. Both are visible from cycle t+1.
- R4: With `queue_en` low the holding register is untouched by edges. If `no_ovw` is set and the capture register is full, the edge is dropped.
- R5: With `queue_en` high and `no_ovw` low, every edge is accepted. The old capture value and its full bit move into the holding register, and the older holding value is lost.
- R6: With `queue_en` and `no_ovw` high, an edge arriving while both registers are full is dropped and nothing changes. If only the capture register is full, it shifts as in R5. If the capture register is empty, only the capture register is loaded and the holding register keeps its value.
- R7: `rd_cap` clears `cap_full_o` and `rd_hold` clears `hold_full_o`. A read is applied before an edge in the same cycle is judged, so a register read in that cycle counts as empty.
- R8: `flag_o` is set by every accepted edge. It is cleared by `flag_clr`, or by `rd_cap` when `fast_clr` is high. In the same cycle, setting wins over clearing.
- R9: `period_o` equals `cap_o` minus `hold_o` modulo 2^16, and it stays correct across a counter wrap.
- R10: After reset, all registers, full bits and the flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counter enable |
| presc_sel | input | 3 | Prescale exponent: divide by 2^presc_sel |
| edge_sel | input | 2 | Edge mode: 00 off, 01 rise, 10 fall, 11 both |
| queue_en | input | 1 | Enable holding register queue |
| no_ovw | input | 1 | Protect unread registers from new edges |
| fast_clr | input | 1 | Capture read also clears the flag |
| rise_i | input | 1 | Qualified rising-edge strobe |
| fall_i | input | 1 | Qualified falling-edge strobe |
| rd_cap | input | 1 | Capture register read strobe |
| rd_hold | input | 1 | Holding register read strobe |
| flag_clr | input | 1 | Explicit flag clear |
| count_o | output | 16 | Free-running counter value |
| cap_o | output | 16 | Capture register |
| hold_o | output | 16 | Holding register |
| cap_full_o | output | 1 | Capture register holds unread data |
| hold_full_o | output | 1 | Holding register holds unread data |
| flag_o | output | 1 | Channel capture flag |
| period_o | output | 16 | cap_o minus hold_o, wrapping |

## Verification
If a full bit is lost or left set wrongly, the damage shows up at the next edge. That edge is then dropped or accepted against the policy, and `cap_o`, `hold_o` and `flag_o` diverge one cycle after it. A wrong prescaler phase shows in `count_o` within one division period. A queue that fails to shift shows immediately in `hold_o` and `period_o`. The bench compares every output against its own model on every cycle, so a divergence is reported in the cycle right after the faulty edge.

// File: rtl/icq_pkg.sv
package icq_pkg;
  localparam int TS_W = 16;
  typedef logic [TS_W-1:0] ts_t;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;

  // wrapping distance from an older to a newer timestamp
  function automatic ts_t ts_delta(ts_t newer, ts_t older);
    return newer - older;
  endfunction
endpackage

// File: rtl/icq_timebase.sv
module icq_timebase
  import icq_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [SEL_W-1:0] presc_sel,
  output ts_t              count_o,
  output logic             tick_o
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;
  ts_t              cnt_q;

  assign mask    = PRE_W'((1 << presc_sel) - 1);
  assign tick_o  = cnt_en && ((pre_q & mask) == mask);
  assign count_o = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      if (cnt_en) pre_q <= pre_q + 1'b1;
      if (tick_o) cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> count_o == ts_t'($past(count_o) + 1'b1)); // R1
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(count_o)); // R1
endmodule

// File: rtl/icq_edge_sel.sv
module icq_edge_sel
  import icq_pkg::*;
(
  input  edge_mode_e mode,
  input  logic       rise_i,
  input  logic       fall_i,
  output logic       evt_o
);
  always_comb begin
    unique case (mode)
      EDGE_RISE: evt_o = rise_i;
      EDGE_FALL: evt_o = fall_i;
      EDGE_ANY:  evt_o = rise_i | fall_i;
      default:   evt_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/icq_queue.sv
module icq_queue
  import icq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  ts_t  count,
  input  logic queue_en,
  input  logic no_ovw,
  input  logic rd_cap,
  input  logic rd_hold,
  output ts_t  cap_o,
  output ts_t  hold_o,
  output logic cap_full_o,
  output logic hold_full_o,
  output logic accept_o
);
  ts_t  cap_q, hold_q;
  logic cap_full_q, hold_full_q;
  logic cf_eff, hf_eff;
  logic accept, shift;

  // reads are applied first, then the edge is judged
  assign cf_eff = cap_full_q & ~rd_cap;
  assign hf_eff = hold_full_q & ~rd_hold;

  always_comb begin
    accept = 1'b0;
    shift  = 1'b0;
    if (evt) begin
      if (!queue_en) begin
        accept = !(no_ovw && cf_eff);
      end else if (!no_ovw) begin
        accept = 1'b1;
        shift  = 1'b1;
      end else begin
        accept = !(cf_eff && hf_eff);
        shift  = accept && cf_eff;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q       <= '0;
      hold_q      <= '0;
      cap_full_q  <= 1'b0;
      hold_full_q <= 1'b0;
    end else begin
      cap_full_q  <= accept ? 1'b1 : cf_eff;
      hold_full_q <= shift ? cf_eff : hf_eff;
      if (accept) cap_q  <= count;
      if (shift)  hold_q <= cap_q;
    end
  end

  assign cap_o       = cap_q;
  assign hold_o      = hold_q;
  assign cap_full_o  = cap_full_q;
  assign hold_full_o = hold_full_q;
  assign accept_o    = accept;

  AST_ACCEPT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> cap_full_q && cap_q == $past(count)); // R3
  AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    shift |=> hold_q == $past(cap_q)); // R5
  AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    evt && queue_en && no_ovw && cap_full_q && hold_full_q && !rd_cap && !rd_hold
    |=> $stable(cap_q) && $stable(hold_q) && cap_full_q && hold_full_q); // R6
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !queue_en |=> $stable(hold_q)); // R4
  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hold && !shift |=> !hold_full_q); // R7
endmodule

// File: rtl/icq_channel.sv
module icq_channel
  import icq_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [SEL_W-1:0] presc_sel,
  input  logic [1:0]       edge_sel,
  input  logic             queue_en,
  input  logic             no_ovw,
  input  logic             fast_clr,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             rd_cap,
  input  logic             rd_hold,
  input  logic             flag_clr,
  output logic [15:0]      count_o,
  output logic [15:0]      cap_o,
  output logic [15:0]      hold_o,
  output logic             cap_full_o,
  output logic             hold_full_o,
  output logic             flag_o,
  output logic [15:0]      period_o
);
  ts_t  count, cap, hold;
  logic tick, evt, accept, flag_q, flag_kill;

  icq_timebase #(.SEL_W(SEL_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .presc_sel(presc_sel),
    .count_o(count), .tick_o(tick)
  );

  icq_edge_sel u_es (
    .mode(edge_mode_e'(edge_sel)), .rise_i(rise_i), .fall_i(fall_i), .evt_o(evt)
  );

  icq_queue u_q (
    .clk(clk), .rst_n(rst_n), .evt(evt), .count(count),
    .queue_en(queue_en), .no_ovw(no_ovw), .rd_cap(rd_cap), .rd_hold(rd_hold),
    .cap_o(cap), .hold_o(hold), .cap_full_o(cap_full_o),
    .hold_full_o(hold_full_o), .accept_o(accept)
  );

  assign flag_kill = flag_clr | (rd_cap & fast_clr);

  always_ff @(posedge clk) begin
    if (!rst_n)         flag_q <= 1'b0;
    else if (accept)    flag_q <= 1'b1;
    else if (flag_kill) flag_q <= 1'b0;
  end

  assign count_o  = count;
  assign cap_o    = cap;
  assign hold_o   = hold;
  assign flag_o   = flag_q;
  assign period_o = ts_delta(cap, hold);

  AST_FLAG_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> flag_o); // R8
  AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    flag_kill && !accept |=> !flag_o); // R8
  AST_EDGE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    edge_sel == 2'b00 |-> !accept); // R2
endmodule

// File: tb/test_icq_channel.sv
module test_icq_channel;
  logic clk = 0, rst_n = 0;
  logic cnt_en = 0, queue_en = 0, no_ovw = 0, fast_clr = 0;
  logic [2:0] presc_sel = 0;
  logic [1:0] edge_sel = 0;
  logic rise_i = 0, fall_i = 0, rd_cap = 0, rd_hold = 0, flag_clr = 0;
  logic [15:0] count_o, cap_o, hold_o, period_o;
  logic cap_full_o, hold_full_o, flag_o;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit done = 0;

  // bench model
  logic [6:0]  m_pre;
  logic [15:0] m_cnt, m_cap, m_hold;
  logic        m_cf, m_hf, m_flag;

  always #2.5 clk = ~clk;

  icq_channel i_icq_channel (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .presc_sel(presc_sel),
    .edge_sel(edge_sel), .queue_en(queue_en), .no_ovw(no_ovw),
    .fast_clr(fast_clr), .rise_i(rise_i), .fall_i(fall_i),
    .rd_cap(rd_cap), .rd_hold(rd_hold), .flag_clr(flag_clr),
    .count_o(count_o), .cap_o(cap_o), .hold_o(hold_o),
    .cap_full_o(cap_full_o), .hold_full_o(hold_full_o),
    .flag_o(flag_o), .period_o(period_o)
  );

  function automatic logic edge_hit(logic [1:0] s, logic r, logic f);
    return (s == 2'b01 && r) || (s == 2'b10 && f) || (s == 2'b11 && (r || f));
  endfunction

  function automatic logic [15:0] wrap_diff(logic [15:0] a, logic [15:0] b);
    logic [16:0] t = {1'b1, a} - {1'b0, b};
    return t[15:0];
  endfunction

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: got %h expected %h", tag, cyc, got, exp);
    end
  endtask

  task automatic compare(string ph);
    chk({ph, " R1 count"}, count_o, m_cnt);
    chk({ph, " R3 cap"}, cap_o, m_cap);
    chk({ph, " R5 hold"}, hold_o, m_hold);
    chk({ph, " R7 cap_full"}, 16'(cap_full_o), 16'(m_cf));
    chk({ph, " R7 hold_full"}, 16'(hold_full_o), 16'(m_hf));
    chk({ph, " R8 flag"}, 16'(flag_o), 16'(m_flag));
    chk({ph, " R9 period"}, period_o, wrap_diff(m_cap, m_hold));
  endtask

  // one clock: inputs already driven at a negedge
  task automatic step(string ph);
    logic [6:0] mask;
    logic cfe, hfe, ev, acc, sh;
    logic [15:0] n_cnt;
    mask = 7'((1 << presc_sel) - 1);
    n_cnt = (cnt_en && ((m_pre & mask) == mask)) ? m_cnt + 16'd1 : m_cnt;
    cfe = m_cf && !rd_cap;
    hfe = m_hf && !rd_hold;
    ev = edge_hit(edge_sel, rise_i, fall_i);
    acc = 0; sh = 0;
    if (ev) begin
      if (!queue_en)    acc = !(no_ovw && cfe);       // R4
      else if (!no_ovw) begin acc = 1; sh = 1; end    // R5
      else begin acc = !(cfe && hfe); sh = acc && cfe; end // R6
    end
    @(posedge clk);
    if (sh) begin m_hold = m_cap; m_hf = cfe; end else m_hf = hfe;
    if (acc) begin m_cap = m_cnt; m_cf = 1; end else m_cf = cfe;
    if (acc) m_flag = 1;
    else if (flag_clr || (rd_cap && fast_clr)) m_flag = 0;
    if (cnt_en) m_pre = m_pre + 7'd1;
    m_cnt = n_cnt;
    @(negedge clk);
    cyc++;
    compare(ph);
  endtask

  task automatic idle();
    rise_i = 0; fall_i = 0; rd_cap = 0; rd_hold = 0; flag_clr = 0;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1c0ffee));
    m_pre = 0; m_cnt = 0; m_cap = 0; m_hold = 0; m_cf = 0; m_hf = 0; m_flag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare("R10 reset");

    // R1: divide by 16
    cnt_en = 1; presc_sel = 3'd4;
    repeat (40) step("R1 prescale");
    cnt_en = 0; repeat (5) step("R1 hold");
    cnt_en = 1;

    // R2: mode 00 ignores everything
    edge_sel = 2'b00;
    rise_i = 1; fall_i = 1; step("R2 off");
    idle(); step("R2 off");
    chk("R2 no capture when off", 16'(cap_full_o), 16'd0);
    edge_sel = 2'b10; rise_i = 1; step("R2 fall-only ignores rise");
    idle(); fall_i = 1; step("R2 fall");
    idle(); step("R2");

    // R9: period of 32 cycles at /16 gives 2
    rd_cap = 1; rd_hold = 1; edge_sel = 2'b01; queue_en = 1; no_ovw = 0;
    step("R7 empty"); idle();
    rise_i = 1; step("R9 first"); idle();
    repeat (31) step("R9 gap");
    rise_i = 1; step("R9 second"); idle();
    chk("R9 period 32 cycles /16", period_o, 16'd2);

    // R6: both full, protected
    no_ovw = 1; rise_i = 1; step("R6 drop"); idle();
    chk("R6 hold kept", 16'(hold_full_o), 16'd1);
    rd_cap = 1; step("R6 read cap"); idle();
    rise_i = 1; step("R6 cap-only load"); idle();

    // R8: set wins over fast clear
    fast_clr = 1; rd_cap = 1; rd_hold = 1; rise_i = 1; step("R8 set wins"); idle();
    chk("R8 set over clear", 16'(flag_o), 16'd1);
    rd_cap = 1; step("R8 fast clear"); idle();
    chk("R8 fast clear", 16'(flag_o), 16'd0);

    // random mix
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 31) == 0) presc_sel = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 15) == 0) begin
        edge_sel = 2'($urandom); queue_en = 1'($urandom);
        no_ovw = 1'($urandom); fast_clr = 1'($urandom);
      end
      cnt_en  = ($urandom_range(0, 9) != 0);
      rise_i  = ($urandom_range(0, 3) == 0);
      fall_i  = ($urandom_range(0, 3) == 0);
      rd_cap  = ($urandom_range(0, 6) == 0);
      rd_hold = ($urandom_range(0, 6) == 0);
      flag_clr = ($urandom_range(0, 9) == 0);
      step("random R2 R4 R5 R6 R7 R8");
    end
    idle();

    // R9 across counter wrap, no prescale
    presc_sel = 0; cnt_en = 1; edge_sel = 2'b11; queue_en = 1; no_ovw = 0;
    while (m_cnt != 16'hFFF0) step("R1 run to wrap");
    fall_i = 1; step("R9 wrap first"); idle();
    repeat (31) step("R9 wrap gap");
    rise_i = 1; step("R9 wrap second"); idle();
    chk("R9 period across wrap", period_o, 16'd32);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule